// File: doc/BRIEF.md
# Integrating ADC Conversion Sequencer

This block times a multi-phase integrating converter. Each conversion cycle has a fixed length. It steps through zero-integrate, integrate, three de-integrate phases, rest phases and times-ten phases. For each phase it drives a one-hot code that the analog switches use. The integrator and comparator sit outside the block. Their state comes in as one comparator bit.

During the de-integrate phases the block runs a signed count in BCD: a sign bit plus five digits, with the top digit limited to 0 or 1. The first de-integrate phase counts in tens. The second runs with the opposite slope and the third runs with the same slope as the first; both count in units. At the end of each cycle a latch window opens. The count is copied to the display register, and the overrange and underrange flags are captured. A hold-mode input can freeze the display or make it follow the running count.

The integrate length depends on the range select. The zero-integrate phase absorbs the difference, so the total cycle length does not change.

Top module: `integ_adc_seq`

## Requirements
- R1: A synchronous reset puts the sequence at the first clock of zero-integrate (phase_o = 5'b00001). After reset, latch_n_o is 1, cycle_done_o is 0, both flags are 0, and the display shows positive zero. range_i is sampled at reset.
- R2: A cycle lasts exactly 30,000 clocks. cycle_done_o is high for one clock only, on the last clock of each cycle. The next clock starts zero-integrate.
- R3: phase_o is one-hot, coded bit0 zero-integrate, bit1 integrate, bit2 de-integrate, bit3 rest, bit4 times-ten. The cycle runs in this order:
  - zero-integrate, then integrate, which together last 13,000 clocks;
  - de-integrate 8,000, rest 1,000, times-ten 1,000;
  - de-integrate 2,000, rest 1,000, times-ten 1,000;
  - de-integrate 2,000, rest 1,000.
- R4: Integrate lasts 10,000 clocks when the sampled range is 0 and 1,000 clocks when it is 1. range_i is sampled only at the last clock of a cycle, for the next cycle. The polarity is comp_i on the last integrate clock. The count is cleared to positive zero on the last zero-integrate clock.
- R5: The count steps once per clock in a de-integrate phase while its enable holds:
  - First de-integrate phase: enabled when comp_i equals the polarity; moves 10 toward the polarity sign.
  - Second de-integrate phase: enabled when comp_i differs from the polarity; moves 1 away from it.
  - Third de-integrate phase: enabled when comp_i equals the polarity; moves 1 toward it.
  disp_sign_o = 1 means negative. Digit k sits at disp_bcd_o[4k+3:4k], with k = 0 the units digit.
- R6: A step from magnitude zero sets the sign to the direction of the step (polarity toward, inverse away) and the magnitude to the step weight. A step against the current sign lowers the magnitude, and the sign is kept when it reaches zero.
- R7: A step that would push the magnitude above 19,999 sets an overflow state instead. The count is then frozen until the next clear.
- R8: latch_n_o is 0 during the last 100 clocks of each cycle. On the clock edge where it falls, the count is copied to the display unless hold mode is selected.
- R9: On that same edge, over_o takes the overflow state and under_o takes (no overflow and magnitude below 1,000). Both are held until the next falling edge.
- R10: With hold_mode_i = 2'd1 the display is never updated.
- R11: With hold_mode_i = 2'd2, on each de-integrate clock the display takes the count from before that edge, so it trails the count by one clock. Codes 2'd0 and 2'd3 mean free-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (oscillator divided by two) |
| rst | input | 1 | Synchronous reset, active high |
| range_i | input | 1 | 0 selects long integrate, 1 selects short integrate |
| comp_i | input | 1 | Comparator decision bit |
| hold_mode_i | input | 2 | 0/3 free-run, 1 hold, 2 live |
| phase_o | output | 5 | One-hot phase code |
| latch_n_o | output | 1 | Low during the end-of-cycle latch window |
| cycle_done_o | output | 1 | High on the last clock of a cycle |
| disp_sign_o | output | 1 | Display sign, 1 = negative |
| disp_bcd_o | output | 20 | Five display BCD digits |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |

## Verification
A position counter that drifts by a single clock shows up at once. The bench compares phase_o against its own position count on every clock, so the first wrong boundary is caught in the cycle where it happens. A wrong polarity, step weight or direction stays inside the count until a latch edge or a live-mode clock brings it to disp_bcd_o. That can be up to one full cycle later. The live-mode scenario therefore exposes such faults within a clock of the step. Faults in overflow and zero crossing show up on the flags and the sign at the next latch edge.

// File: rtl/integ_adc_seq.sv
module integ_adc_seq #(
  parameter int CYCLE     = 30000,
  parameter int INT_LONG  = 10000,
  parameter int INT_SHORT = 1000,
  parameter int DE1_LEN   = 8000,
  parameter int DE_LEN    = 2000,
  parameter int REST_LEN  = 1000,
  parameter int X10_LEN   = 1000,
  parameter int LATCH_LEN = 100,
  parameter int DIGITS    = 5,
  parameter int UR_DIGIT  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                range_i,
  input  logic                comp_i,
  input  logic [1:0]          hold_mode_i,
  output logic [4:0]          phase_o,
  output logic                latch_n_o,
  output logic                cycle_done_o,
  output logic                disp_sign_o,
  output logic [4*DIGITS-1:0] disp_bcd_o,
  output logic                over_o,
  output logic                under_o
);
  localparam int PW   = $clog2(CYCLE);
  localparam int MW   = 4 * DIGITS;
  localparam int TAIL = DE1_LEN + 2 * DE_LEN + 3 * REST_LEN + 2 * X10_LEN;
  localparam logic [PW-1:0] ZI_LONG  = PW'(CYCLE - TAIL - INT_LONG);
  localparam logic [PW-1:0] ZI_SHORT = PW'(CYCLE - TAIL - INT_SHORT);
  localparam logic [PW-1:0] E_INT = PW'(CYCLE - TAIL);
  localparam logic [PW-1:0] E_D1  = PW'(CYCLE - TAIL + DE1_LEN);
  localparam logic [PW-1:0] E_R1  = PW'(CYCLE - TAIL + DE1_LEN + REST_LEN);
  localparam logic [PW-1:0] E_X1  = PW'(CYCLE - TAIL + DE1_LEN + REST_LEN + X10_LEN);
  localparam logic [PW-1:0] E_D2  = PW'(CYCLE - TAIL + DE1_LEN + REST_LEN + X10_LEN + DE_LEN);
  localparam logic [PW-1:0] E_R2  = PW'(CYCLE - TAIL + DE1_LEN + 2 * REST_LEN + X10_LEN + DE_LEN);
  localparam logic [PW-1:0] E_X2  = PW'(CYCLE - TAIL + DE1_LEN + 2 * REST_LEN + 2 * X10_LEN + DE_LEN);
  localparam logic [PW-1:0] E_D3  = PW'(CYCLE - REST_LEN);
  localparam logic [PW-1:0] LAST  = PW'(CYCLE - 1);
  localparam logic [PW-1:0] WIN   = PW'(CYCLE - LATCH_LEN);

  typedef enum logic [3:0] {S_ZI, S_INT, S_D1, S_R1, S_X1, S_D2, S_R2, S_X2, S_D3, S_R3} step_t;

  logic [PW-1:0] pos, zi_end;
  logic          rng_q, pol, neg, ovf;
  logic [MW-1:0] mag, mag_inc, mag_dec;
  step_t         step;
  logic          cnt_en, toward, wide, is_de;

  function automatic logic [MW-1:0] bcd_inc(input logic [MW-1:0] v, input logic k);
    logic [MW-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (c && (d > 0 || !k)) begin
        if (r[4*d +: 4] == 4'd9 && d < DIGITS - 1) r[4*d +: 4] = 4'd0;
        else begin
          r[4*d +: 4] = r[4*d +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [MW-1:0] bcd_dec(input logic [MW-1:0] v);
    logic [MW-1:0] r;
    logic b;
    r = v;
    b = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (b) begin
        if (r[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
        else begin
          r[4*d +: 4] = r[4*d +: 4] - 4'd1;
          b = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign zi_end = rng_q ? ZI_SHORT : ZI_LONG;

  always_comb begin
    if      (pos < zi_end) step = S_ZI;
    else if (pos < E_INT)  step = S_INT;
    else if (pos < E_D1)   step = S_D1;
    else if (pos < E_R1)   step = S_R1;
    else if (pos < E_X1)   step = S_X1;
    else if (pos < E_D2)   step = S_D2;
    else if (pos < E_R2)   step = S_R2;
    else if (pos < E_X2)   step = S_X2;
    else if (pos < E_D3)   step = S_D3;
    else                   step = S_R3;
  end

  always_comb begin
    cnt_en = 1'b0;
    toward = 1'b1;
    wide   = 1'b0;
    unique case (step)
      S_D1:    begin cnt_en = (comp_i == pol); wide = 1'b1; end
      S_D2:    begin cnt_en = (comp_i != pol); toward = 1'b0; end
      S_D3:    cnt_en = (comp_i == pol);
      default: ;
    endcase
  end

  assign is_de   = (step == S_D1) || (step == S_D2) || (step == S_D3);
  assign mag_inc = bcd_inc(mag, wide);
  assign mag_dec = bcd_dec(mag);

  assign phase_o[0]   = (step == S_ZI);
  assign phase_o[1]   = (step == S_INT);
  assign phase_o[2]   = is_de;
  assign phase_o[3]   = (step == S_R1) || (step == S_R2) || (step == S_R3);
  assign phase_o[4]   = (step == S_X1) || (step == S_X2);
  assign latch_n_o    = (pos < WIN);
  assign cycle_done_o = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      rng_q <= range_i;
    end else begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
      if (pos == LAST) rng_q <= range_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= 1'b0;
      neg <= 1'b0;
      ovf <= 1'b0;
      mag <= '0;
    end else if (pos == zi_end - 1'b1) begin
      neg <= 1'b0;
      ovf <= 1'b0;
      mag <= '0;
    end else begin
      if (pos == E_INT - 1'b1) pol <= comp_i;
      if (cnt_en && !ovf) begin
        if (mag == '0) begin
          neg <= toward ? pol : ~pol;
          mag <= mag_inc;
        end else if ((neg == pol) == toward) begin
          if (mag_inc[MW-1 -: 4] > 4'd1) ovf <= 1'b1;
          else mag <= mag_inc;
        end else begin
          mag <= mag_dec;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_sign_o <= 1'b0;
      disp_bcd_o  <= '0;
      over_o      <= 1'b0;
      under_o     <= 1'b0;
    end else if (pos == WIN - 1'b1) begin
      over_o  <= ovf;
      under_o <= !ovf && (mag[MW-1 : 4*UR_DIGIT] == '0);
      if (hold_mode_i != 2'd1) begin
        disp_sign_o <= neg;
        disp_bcd_o  <= mag;
      end
    end else if (hold_mode_i == 2'd2 && is_de) begin
      disp_sign_o <= neg;
      disp_bcd_o  <= mag;
    end
  end
endmodule

module integ_adc_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  hold_mode_i,
  input logic [4:0]  phase_o,
  input logic        latch_n_o,
  input logic        cycle_done_o,
  input logic        disp_sign_o,
  input logic [19:0] disp_bcd_o,
  input logic        over_o,
  input logic        under_o
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1); // R3
  AST_WRAP_TO_ZI: assert property (@(posedge clk) disable iff (rst)
    cycle_done_o |=> phase_o[0] && latch_n_o && !cycle_done_o); // R2
  AST_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    cycle_done_o |-> !latch_n_o && phase_o[3]); // R8
  AST_WINDOW_IN_REST: assert property (@(posedge clk) disable iff (rst)
    !latch_n_o |-> phase_o[3]); // R8
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$fell(latch_n_o) |-> $stable(over_o) && $stable(under_o)); // R9
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    hold_mode_i == 2'd1 |=> $stable(disp_bcd_o) && $stable(disp_sign_o)); // R10
endmodule

bind integ_adc_seq integ_adc_seq_chk u_chk (
  .clk(clk), .rst(rst), .hold_mode_i(hold_mode_i), .phase_o(phase_o),
  .latch_n_o(latch_n_o), .cycle_done_o(cycle_done_o), .disp_sign_o(disp_sign_o),
  .disp_bcd_o(disp_bcd_o), .over_o(over_o), .under_o(under_o)
);

// File: tb/integ_adc_seq_tb.sv
module integ_adc_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        range_i = 1'b0;
  logic        comp_i = 1'b0;
  logic [1:0]  hold_mode_i = 2'd0;
  logic [4:0]  phase_o;
  logic        latch_n_o, cycle_done_o, disp_sign_o, over_o, under_o;
  logic [19:0] disp_bcd_o;

  integ_adc_seq u_dut (
    .clk(clk), .rst(rst), .range_i(range_i), .comp_i(comp_i), .hold_mode_i(hold_mode_i),
    .phase_o(phase_o), .latch_n_o(latch_n_o), .cycle_done_o(cycle_done_o),
    .disp_sign_o(disp_sign_o), .disp_bcd_o(disp_bcd_o), .over_o(over_o), .under_o(under_o)
  );

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0, scn = 0;
  int mpos = 0, mpol = 0, mneg = 0, mmag = 0, movf = 0;
  int dneg = 0, dmag = 0, mover = 0, munder = 0;
  bit mrng = 0;

  function automatic int zi_len(bit r);
    return r ? 12000 : 3000;
  endfunction

  function automatic int step_of(int p, bit r);
    int e[9];
    e = '{zi_len(r), 13000, 21000, 22000, 23000, 25000, 26000, 27000, 29000};
    for (int i = 0; i < 9; i++) if (p < e[i]) return i;
    return 9;
  endfunction

  function automatic logic [4:0] phase_of(int s);
    case (s)
      0: return 5'b00001;
      1: return 5'b00010;
      2, 5, 8: return 5'b00100;
      4, 7: return 5'b10000;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic logic [19:0] to_bcd(int v);
    logic [19:0] r;
    for (int d = 0; d < 5; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic bit rng_of(int s);
    return s == 1;
  endfunction

  function automatic logic [1:0] mode_of(int s);
    return (s == 3) ? 2'd1 : (s == 4) ? 2'd2 : 2'd0;
  endfunction

  function automatic bit comp_of(int s, int p);
    if (s == 1) return 1'b0;
    if (s == 2) return (p >= 13000 && p < 21000) || (p >= 23000 && p < 23003) || (p >= 27000 && p < 29000);
    return (p < 13000) || (p >= 13000 && p < 13500) || (p >= 23030 && p < 25000) || (p >= 27000 && p < 27007);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s at pos %0d scn %0d: actual %h expected %h", tag, mpos, scn, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int s, w;
    bit tow, en;
    cycles++;
    if (rst) begin
      mpos = 0; mrng = range_i; mpol = 0; mneg = 0; mmag = 0; movf = 0;
      dneg = 0; dmag = 0; mover = 0; munder = 0;
    end else begin
      s = step_of(mpos, mrng);
      if (mpos == 29899) begin
        mover = movf;
        munder = (!movf && mmag < 1000);
        if (hold_mode_i != 2'd1) begin dneg = mneg; dmag = mmag; end
      end else if (hold_mode_i == 2'd2 && (s == 2 || s == 5 || s == 8)) begin
        dneg = mneg; dmag = mmag;
      end
      if (mpos == zi_len(mrng) - 1) begin
        mneg = 0; mmag = 0; movf = 0;
      end else begin
        if (mpos == 12999) mpol = comp_i;
        en = 0; tow = 1; w = 1;
        if (s == 2) begin en = (comp_i == mpol); w = 10; end
        if (s == 5) begin en = (comp_i != mpol); tow = 0; end
        if (s == 8) en = (comp_i == mpol);
        if (en && !movf) begin
          if (mmag == 0) begin mneg = tow ? mpol : !mpol; mmag = w; end
          else if ((mneg == mpol) == tow) begin
            if (mmag + w > 19999) movf = 1; else mmag += w;
          end else mmag -= w;
        end
      end
      if (mpos == 29999) begin mpos = 0; mrng = range_i; scn++; end
      else mpos++;
    end
  end

  always @(negedge clk) begin
    int s, nxt;
    string dtag;
    if (rst) begin
      check("R1 phase", 32'(phase_o), 32'b00001);
      check("R1 latch", 32'(latch_n_o), 1);
      check("R1 flags", 32'({over_o, under_o, disp_sign_o}), 0);
      check("R1 display", 32'(disp_bcd_o), 0);
    end else begin
      s = step_of(mpos, mrng);
      check("R3 R4 phase", 32'(phase_o), 32'(phase_of(s)));
      check("R2 done", 32'(cycle_done_o), 32'(mpos == 29999));
      check("R8 latch_n", 32'(latch_n_o), 32'(mpos < 29900));
      dtag = (scn == 3) ? "R10 display" : (scn == 4) ? "R11 display" :
             (scn == 2) ? "R6 display" : "R5 display";
      check(dtag, 32'({disp_sign_o, disp_bcd_o}), 32'({dneg[0], to_bcd(dmag)}));
      check(scn == 2 ? "R7 over" : "R9 over", 32'(over_o), 32'(mover));
      check("R9 under", 32'(under_o), 32'(munder));
    end
    nxt = (mpos == 29999) ? scn + 1 : scn;
    range_i     = rng_of(nxt);
    hold_mode_i = mode_of(scn);
    comp_i      = comp_of(scn, mpos);
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    while (scn < 5 && cycles < 190000) @(posedge clk);
    if (scn < 5) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual scenario %0d expected 5", scn);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule